// File: doc/BRIEF.md
# Canvas descriptor lookup table

This block keeps a table of 256 pixel-buffer descriptors for the display and video engines. Each descriptor gives a buffer base address and a width, both in 8-byte units, plus a height in lines, a wrap mode, a block (tiling) mode and a byte-swap code. Software fills an entry through a register bus that decodes three 32-bit words. Two staging words together hold one descriptor; the width field is split between them. The third word is a command register. It carries the table index and two strobe bits. A write strobe copies the staged descriptor into the indexed entry. A read strobe copies the indexed entry back into the staging words.

Each command takes one extra cycle to finish. During that cycle the bus is held off with a ready signal. So any access issued straight after a command, such as a read of the upper staging word, completes only after the table has been updated. Software can use that read as a flush.

A separate lookup port lets a pixel engine fetch the decoded fields of any entry. It presents an index, and the fields appear one clock later.

Top module: `canvas_desc_table`

## Requirements
- R1: After reset every table entry, both staging words and the command index are zero, so bus reads of offsets 0x0, 0x4 and 0x8 return 0 and the lookup port returns all-zero fields for any index.
- R2: A bus write to offset 0x0 sets the low staging word and a write to offset 0x4 sets the high staging word; reads return them, with bits [31:30] of the high word always reading 0.
- R3: A command write (offset 0x8) with bit 9 set copies the staged descriptor into the entry selected by bits [7:0], leaving all other entries unchanged.
- R4: Field layout: low word bits [28:0] hold the base address and bits [31:29] the width bits [2:0]; high word bits [8:0] hold width bits [11:3], [21:9] the 13-bit height, [23:22] wrap (0 none, 1 X, 2 Y), [25:24] block mode (0 linear, 1 32x32, 2 64x64), [29:26] swap code (0x1 16-bit, 0x3 32-bit, 0x7 64-bit, 0xF 128-bit).
- R5: A command write with bit 8 set and bit 9 clear loads the selected entry into both staging words in the following cycle.
- R6: When bits 9 and 8 are both set, only the commit takes place: the entry receives the staged descriptor and the staging words keep the values that were written to them.
- R7: A read of offset 0x8 returns the last written index in bits [7:0] and zero in every other bit, strobes included.
- R8: In the cycle after a command with either strobe is accepted, bus_ready is low for exactly one cycle, so an access presented at once is accepted only after the command has completed.
- R9: The lookup port outputs the fields of the entry at lk_idx one clock edge after the index is presented.
- R10: Every accepted bus read yields bus_rvalid exactly one cycle later; offset 0xC reads as 0 and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access request |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 4 | Byte offset; bits [3:2] select the word |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Access accepted when high with bus_sel |
| bus_rvalid | output | 1 | Read data valid pulse |
| bus_rdata | output | 32 | Read data |
| lk_idx | input | 8 | Lookup index |
| lk_base | output | 29 | Base address in 8-byte units |
| lk_width | output | 12 | Width in 8-byte units |
| lk_height | output | 13 | Height in lines |
| lk_wrap | output | 2 | Wrap mode code |
| lk_blkmode | output | 2 | Block mode code |
| lk_endian | output | 4 | Byte-swap code |

## Verification
The bench reads the high staging word immediately after a commit and counts the stall cycles. A design without the one-cycle hold would return the response early, or with the wrong count. Descriptors whose width uses bits on both sides of the word split are committed, and the fields are checked at the lookup port. A design that placed the width bits wrongly would return a scrambled width. A command with both strobes set must commit rather than reload, or the entry and the staging words come back stale. Index 255 and unmapped offset 0xC are also exercised, to catch truncated decoding and writes that leak into other words.

// File: rtl/canvas_pkg.sv
package canvas_pkg;

    localparam int BASE_W   = 29;
    localparam int WIDTH_W  = 12;
    localparam int HEIGHT_W = 13;
    localparam int HI_W     = 30;
    localparam int WLO_W    = 32 - BASE_W;
    localparam int CMD_WR_BIT = 9;
    localparam int CMD_RD_BIT = 8;

    typedef struct packed {
        logic [3:0]          endian;
        logic [1:0]          blkmode;
        logic [1:0]          wrap;
        logic [HEIGHT_W-1:0] height;
        logic [WIDTH_W-1:0]  width;
        logic [BASE_W-1:0]   base;
    } desc_t;

    typedef enum logic [1:0] {
        SEL_LO   = 2'd0,
        SEL_HI   = 2'd1,
        SEL_CMD  = 2'd2,
        SEL_NONE = 2'd3
    } word_sel_e;

    function automatic logic [31:0] desc_lo(desc_t d);
        return {d.width[WLO_W-1:0], d.base};
    endfunction

    function automatic logic [HI_W-1:0] desc_hi(desc_t d);
        return {d.endian, d.blkmode, d.wrap, d.height, d.width[WIDTH_W-1:WLO_W]};
    endfunction

    function automatic desc_t desc_unpack(logic [31:0] lo, logic [HI_W-1:0] hi);
        desc_t d;
        d.base    = lo[BASE_W-1:0];
        d.width   = {hi[WIDTH_W-WLO_W-1:0], lo[31:BASE_W]};
        d.height  = hi[21:9];
        d.wrap    = hi[23:22];
        d.blkmode = hi[25:24];
        d.endian  = hi[29:26];
        return d;
    endfunction

endpackage

// File: rtl/canvas_regif.sv
module canvas_regif
    import canvas_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_we,
    input  logic [3:0]       bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic             bus_ready,
    output logic             bus_rvalid,
    output logic [31:0]      bus_rdata,
    output logic             op_valid,
    output logic             op_write,
    output logic [IDX_W-1:0] op_idx,
    output desc_t            stage_desc,
    input  desc_t            entry_desc
);

    typedef struct packed {
        logic [31:0]      lo;
        logic [HI_W-1:0]  hi;
        logic [IDX_W-1:0] idx;
        logic             pend;
        logic             pend_wr;
        logic             rvalid;
        logic [31:0]      rdata;
    } rif_t;

    rif_t      st_d, st_q;
    word_sel_e wsel;
    logic      accept;

    always_comb begin
        st_d   = st_q;
        st_d.rvalid = 1'b0;
        wsel   = word_sel_e'(bus_addr[3:2]);
        accept = bus_sel && !st_q.pend;

        if (accept) begin
            if (bus_we) begin
                case (wsel)
                    SEL_LO:  st_d.lo = bus_wdata;
                    SEL_HI:  st_d.hi = bus_wdata[HI_W-1:0];
                    SEL_CMD: begin
                        st_d.idx = bus_wdata[IDX_W-1:0];
                        if (bus_wdata[CMD_WR_BIT]) begin
                            st_d.pend    = 1'b1;
                            st_d.pend_wr = 1'b1;
                        end else if (bus_wdata[CMD_RD_BIT]) begin
                            st_d.pend    = 1'b1;
                            st_d.pend_wr = 1'b0;
                        end
                    end
                    default: ;
                endcase
            end else begin
                st_d.rvalid = 1'b1;
                case (wsel)
                    SEL_LO:  st_d.rdata = st_q.lo;
                    SEL_HI:  st_d.rdata = 32'(st_q.hi);
                    SEL_CMD: st_d.rdata = 32'(st_q.idx);
                    default: st_d.rdata = '0;
                endcase
            end
        end

        // a pending command retires here; reloads come from the table
        if (st_q.pend) begin
            st_d.pend = 1'b0;
            if (!st_q.pend_wr) begin
                st_d.lo = desc_lo(entry_desc);
                st_d.hi = desc_hi(entry_desc);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_ready  = !st_q.pend;
    assign bus_rvalid = st_q.rvalid;
    assign bus_rdata  = st_q.rdata;
    assign op_valid   = st_q.pend;
    assign op_write   = st_q.pend_wr;
    assign op_idx     = st_q.idx;
    assign stage_desc = desc_unpack(st_q.lo, st_q.hi);

endmodule

// File: rtl/canvas_store.sv
module canvas_store
    import canvas_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  desc_t            wr_desc,
    input  logic [IDX_W-1:0] rd_idx,
    output desc_t            rd_desc,
    input  logic [IDX_W-1:0] lk_idx,
    output desc_t            lk_desc
);

    localparam int ENTRIES = 1 << IDX_W;

    desc_t mem_d [ENTRIES];
    desc_t mem_q [ENTRIES];

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) mem_d[i] = mem_q[i];
        if (wr_en) mem_d[wr_idx] = wr_desc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) mem_q[i] <= '0;
        end else begin
            for (int i = 0; i < ENTRIES; i++) mem_q[i] <= mem_d[i];
        end
    end

    assign rd_desc = mem_q[rd_idx];
    assign lk_desc = mem_q[lk_idx];

endmodule

// File: rtl/canvas_lookup.sv
module canvas_lookup
    import canvas_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  desc_t raw_desc,
    output desc_t lk_desc
);

    desc_t lk_d, lk_q;

    always_comb begin
        lk_d = raw_desc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lk_q <= '0;
        else        lk_q <= lk_d;
    end

    assign lk_desc = lk_q;

endmodule

// File: rtl/canvas_desc_table.sv
module canvas_desc_table
    import canvas_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_we,
    input  logic [3:0]          bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic                bus_ready,
    output logic                bus_rvalid,
    output logic [31:0]         bus_rdata,
    input  logic [IDX_W-1:0]    lk_idx,
    output logic [BASE_W-1:0]   lk_base,
    output logic [WIDTH_W-1:0]  lk_width,
    output logic [HEIGHT_W-1:0] lk_height,
    output logic [1:0]          lk_wrap,
    output logic [1:0]          lk_blkmode,
    output logic [3:0]          lk_endian
);

    logic             op_valid;
    logic             op_write;
    logic [IDX_W-1:0] op_idx;
    desc_t            stage_desc;
    desc_t            entry_desc;
    desc_t            raw_lk;
    desc_t            lk_desc;

    canvas_regif #(.IDX_W(IDX_W)) regif_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_ready  (bus_ready),
        .bus_rvalid (bus_rvalid),
        .bus_rdata  (bus_rdata),
        .op_valid   (op_valid),
        .op_write   (op_write),
        .op_idx     (op_idx),
        .stage_desc (stage_desc),
        .entry_desc (entry_desc)
    );

    canvas_store #(.IDX_W(IDX_W)) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (op_valid && op_write),
        .wr_idx  (op_idx),
        .wr_desc (stage_desc),
        .rd_idx  (op_idx),
        .rd_desc (entry_desc),
        .lk_idx  (lk_idx),
        .lk_desc (raw_lk)
    );

    canvas_lookup lookup_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_desc (raw_lk),
        .lk_desc  (lk_desc)
    );

    assign lk_base    = lk_desc.base;
    assign lk_width   = lk_desc.width;
    assign lk_height  = lk_desc.height;
    assign lk_wrap    = lk_desc.wrap;
    assign lk_blkmode = lk_desc.blkmode;
    assign lk_endian  = lk_desc.endian;

endmodule

// File: rtl/canvas_desc_table_chk.sv
module canvas_desc_table_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_sel,
    input logic        bus_we,
    input logic [3:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic        bus_ready,
    input logic        bus_rvalid,
    input logic [31:0] bus_rdata
);

    logic acc_rd, acc_cmd;
    assign acc_rd  = bus_sel && bus_ready && !bus_we;
    assign acc_cmd = bus_sel && bus_ready && bus_we && (bus_addr[3:2] == 2'd2)
                     && (bus_wdata[9] || bus_wdata[8]);

    assert_cmd_holds_bus_R8: assert property (@(posedge clk) disable iff (!rst_n)
        acc_cmd |=> !bus_ready);

    assert_hold_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ready |=> bus_ready);

    assert_read_responds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        acc_rd |=> bus_rvalid);

    assert_no_stray_response_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_rd |=> !bus_rvalid);

    assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd && bus_addr[3:2] == 2'd3) |=> (bus_rdata == 32'd0));

    assert_cmd_strobes_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd && bus_addr[3:2] == 2'd2) |=> (bus_rdata[31:8] == 24'd0));

    assert_hi_top_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd && bus_addr[3:2] == 2'd1) |=> (bus_rdata[31:30] == 2'd0));

endmodule

bind canvas_desc_table canvas_desc_table_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_ready  (bus_ready),
    .bus_rvalid (bus_rvalid),
    .bus_rdata  (bus_rdata)
);

// File: tb/canvas_desc_table_tb_top.sv
module canvas_desc_table_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ready, bus_rvalid;
    logic [31:0] bus_rdata;
    logic [7:0]  lk_idx = '0;
    logic [28:0] lk_base;
    logic [11:0] lk_width;
    logic [12:0] lk_height;
    logic [1:0]  lk_wrap, lk_blkmode;
    logic [3:0]  lk_endian;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    canvas_desc_table dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
        .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .lk_idx(lk_idx),
        .lk_base(lk_base), .lk_width(lk_width), .lk_height(lk_height),
        .lk_wrap(lk_wrap), .lk_blkmode(lk_blkmode), .lk_endian(lk_endian)
    );

    // descriptor as {endian, blkmode, wrap, height, width, base}
    function automatic logic [61:0] mkd(logic [28:0] b, logic [11:0] w, logic [12:0] h,
                                        logic [1:0] wr, logic [1:0] bm, logic [3:0] en);
        return {en, bm, wr, h, w, b};
    endfunction
    function automatic logic [31:0] lo_of(logic [61:0] d);
        return {d[31:29], d[28:0]};
    endfunction
    function automatic logic [31:0] hi_of(logic [61:0] d);
        return {2'b00, d[61:58], d[57:56], d[55:54], d[53:41], d[40:32]};
    endfunction

    task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on each read response
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R10 unexpected response", 64'(bus_rdata), 64'hx);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(bus_rdata === e, t, 64'(bus_rdata), 64'(e));
            end
        end
    end

    task automatic bus_wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        while (!bus_ready) @(negedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_rd(logic [3:0] a, logic [31:0] e, string t);
        @(negedge clk);
        exp_q.push_back(e); tag_q.push_back(t);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        while (!bus_ready) @(negedge clk);
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic stage(logic [61:0] d);
        bus_wr(4'h0, lo_of(d));
        bus_wr(4'h4, hi_of(d));
    endtask

    task automatic lookup(logic [7:0] i, logic [61:0] e, string t);
        logic [61:0] a;
        @(negedge clk);
        lk_idx = i;
        @(negedge clk);
        a = {lk_endian, lk_blkmode, lk_wrap, lk_height, lk_width, lk_base};
        check(a === e, t, 64'(a), 64'(e));
    endtask

    initial begin
        #(4 * 200000);
        check(1'b0, "watchdog", 64'd0, 64'd1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [61:0] da, db, dc, dd;
        int stalls;
        da = mkd(29'h1234567, 12'hABC, 13'h1555, 2'd2, 2'd1, 4'h7);
        db = mkd(29'h1FFFFFFF, 12'hFFF, 13'h1FFF, 2'd1, 2'd2, 4'hF);
        dc = mkd(29'h0000ABC, 12'h008, 13'h0010, 2'd0, 2'd0, 4'h1);
        dd = mkd(29'h0F0F0F0, 12'h3A5, 13'h0437, 2'd0, 2'd1, 4'h3);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_rd(4'h0, 32'd0, "R1 low word after reset");
        bus_rd(4'h4, 32'd0, "R1 high word after reset");
        bus_rd(4'h8, 32'd0, "R1 command after reset");
        lookup(8'd0, 62'd0, "R1 entry 0 after reset");
        lookup(8'd255, 62'd0, "R1 entry 255 after reset");

        // R2 staging words, top bits of high word read zero
        bus_wr(4'h4, 32'hFFFF_FFFF);
        bus_rd(4'h4, 32'h3FFF_FFFF, "R2 high word masking");
        stage(da);
        bus_rd(4'h0, lo_of(da), "R2 low word readback");
        bus_rd(4'h4, hi_of(da), "R2 high word readback");

        // R3/R8 commit then flush read of high word
        bus_wr(4'h8, 32'h0000_0205);
        check(bus_ready === 1'b0, "R8 ready low after commit", 64'(bus_ready), 64'd0);
        exp_q.push_back(hi_of(da)); tag_q.push_back("R8 flush read data");
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 4'h4;
        stalls = 0;
        while (!bus_ready) begin @(negedge clk); stalls++; end
        @(negedge clk);
        bus_sel = 1'b0;
        check(stalls == 1, "R8 stall count", 64'(stalls), 64'd1);

        // R3/R4/R9 lookup of committed entry
        lookup(8'd5, da, "R4 fields of entry 5");
        lookup(8'd4, 62'd0, "R3 neighbour entry untouched");
        // R9: output holds until the next edge
        @(negedge clk);
        lk_idx = 8'd5;
        #1;
        check(lk_base === 29'd0, "R9 no change before edge", 64'(lk_base), 64'd0);
        @(negedge clk);
        check(lk_base === 29'h1234567, "R9 one cycle latency", 64'(lk_base), 64'h1234567);

        // R7 command readback
        bus_rd(4'h8, 32'h0000_0005, "R7 index readback");

        // R4 boundary index with other encodings
        stage(db);
        bus_wr(4'h8, 32'h0000_02FF);
        lookup(8'd255, db, "R4 entry 255 64x64 swap128");
        lookup(8'd5, da, "R3 entry 5 kept");

        // R5 reload entry 5 over junk staging
        stage(dc);
        bus_wr(4'h8, 32'h0000_0105);
        bus_rd(4'h0, lo_of(da), "R5 reload low word");
        bus_rd(4'h4, hi_of(da), "R5 reload high word");
        bus_rd(4'h8, 32'h0000_0005, "R7 strobes read zero");

        // R6 both strobes: commit wins
        stage(dd);
        bus_wr(4'h8, 32'h0000_0307);
        lookup(8'd7, dd, "R6 entry 7 committed");
        bus_rd(4'h0, lo_of(dd), "R6 low word kept");
        bus_rd(4'h4, hi_of(dd), "R6 high word kept");

        // R10 unmapped offset
        bus_wr(4'hC, 32'hDEAD_BEEF);
        bus_rd(4'hC, 32'd0, "R10 unmapped reads zero");
        bus_rd(4'h0, lo_of(dd), "R10 unmapped write ignored");
        bus_rd(4'h8, 32'h0000_0007, "R10 command untouched");

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R10 responses outstanding", 64'(exp_q.size()), 64'd0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule